// File: doc/BRIEF.md
# Indexed Multisample Fragment Compressor

This block reduces the sixteen samples of one antialiased pixel to two 128-bit words. Every sample carries a colour, a depth and a stencil value. The block finds the distinct fragments among them and stores at most three of them as a palette. A 2-bit index per sample selects that sample's palette entry. The colour word holds the palette colours and the index set. The depth/stencil word holds the palette depth and stencil values, and it uses the same indices. Every sample points at a whole fragment, so an edge where two primitives cross inside the pixel keeps one fragment per sample and is not blended.

A pixel with four or more distinct fragments cannot be packed. The block raises a fallback flag, drives both words to zero and passes the sixteen raw samples out unchanged. The packer accepts one pixel per clock and delivers it two clocks later. A separate unpacker turns a word pair back into sixteen samples one clock after it is presented. Packing followed by unpacking returns every sample bit for bit.

Top module: `msaa_frag_codec`

## Requirements
- R1: A pixel presented with `in_valid` high at a rising edge appears with `out_valid` high after the second following rising edge. One pixel is accepted on every clock.
- R2: In the colour word, palette slot k holds its colour in bits [32k+31:32k] for k = 0..2. The index of sample s sits in bits [96+2s+1:96+2s].
- R3: In the depth/stencil word, slot k occupies bits [40k+39:40k], with depth in the low 32 bits and stencil in the upper 8 bits. Bits [127:120] are always zero.
- R4: Slots are filled in order of first appearance while samples are scanned from 0 to 15. Sample 0 therefore always has index 0. Slots that are not used are zero in both words.
- R5: Two samples share a slot only when colour, depth and stencil are all equal. A difference in stencil alone needs a new slot.
- R6: A packed pixel never uses index value 3, which is reserved for an unused sample.
- R7: A pixel with more than three distinct fragments sets `out_uncomp`, drives both words to zero and presents its samples unchanged on the raw outputs. For a packable pixel the raw outputs are zero.
- R8: The unpacker raises `un_out_valid` one clock after `un_valid` and holds it low one clock after `un_valid` is low.
- R9: The unpacker gives each sample the colour, depth and stencil of the slot its index names. A sample with index 3 decodes to all zeros.
- R10: Unpacking a packed pixel reproduces all sixteen samples exactly.
- R11: During reset `out_valid`, `out_uncomp`, `un_out_valid` and both packed words are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Pixel present on the sample inputs |
| in_color | input | 512 | Sample colours, sample s in bits [32s+31:32s] |
| in_depth | input | 512 | Sample depths, sample s in bits [32s+31:32s] |
| in_stencil | input | 128 | Sample stencils, sample s in bits [8s+7:8s] |
| out_valid | output | 1 | Packed result present |
| out_uncomp | output | 1 | Pixel could not be packed, raw outputs carry it |
| out_color_word | output | 128 | Palette colours and sample indices |
| out_ds_word | output | 128 | Palette depth and stencil entries |
| out_raw_color | output | 512 | Raw colours on fallback |
| out_raw_depth | output | 512 | Raw depths on fallback |
| out_raw_stencil | output | 128 | Raw stencils on fallback |
| un_valid | input | 1 | Word pair present for unpacking |
| un_color_word | input | 128 | Colour word to unpack |
| un_ds_word | input | 128 | Depth/stencil word to unpack |
| un_out_valid | output | 1 | Unpacked samples present |
| un_color | output | 512 | Unpacked colours |
| un_depth | output | 512 | Unpacked depths |
| un_stencil | output | 128 | Unpacked stencils |

## Verification
The packer and the unpacker have separate pipelines, and both can be busy on the same clock edge. The bench returns each packed word pair to the unpacker inputs in the cycle it appears. The packer keeps taking a new pixel in that same cycle, so a fresh pixel enters the packer while an older one is being decoded. Each packed pixel is judged twice: once against words that the bench builds itself from first-appearance ranking, and once one clock later against the original samples.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
  localparam int NS     = 16;
  localparam int NSLOT  = 3;
  localparam int CW     = 32;
  localparam int DW     = 32;
  localparam int SW     = 8;
  localparam int IW     = $clog2(NSLOT + 1);
  localparam int EW     = DW + SW;
  localparam int WORD_W = 128;
  localparam int IDX_LO = NSLOT * CW;
  localparam int PAD_LO = NSLOT * EW;
  localparam logic [IW-1:0] IDX_NONE = IW'(NSLOT);

  typedef struct packed {
    logic [CW-1:0] col;
    logic [DW-1:0] dep;
    logic [SW-1:0] stn;
  } frag_t;

  typedef frag_t [NSLOT-1:0] palette_t;

  function automatic frag_t frag_at(input logic [NS*CW-1:0] c, input logic [NS*DW-1:0] d,
                                    input logic [NS*SW-1:0] s, input int i);
    frag_t f;
    f.col = c[i*CW +: CW];
    f.dep = d[i*DW +: DW];
    f.stn = s[i*SW +: SW];
    return f;
  endfunction

  function automatic logic [WORD_W-1:0] make_color_word(input palette_t p, input logic [NS*IW-1:0] idx);
    logic [WORD_W-1:0] w;
    w = '0;
    for (int k = 0; k < NSLOT; k++) w[k*CW +: CW] = p[k].col;
    w[IDX_LO +: NS*IW] = idx;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] make_ds_word(input palette_t p);
    logic [WORD_W-1:0] w;
    w = '0;
    for (int k = 0; k < NSLOT; k++) w[k*EW +: EW] = {p[k].stn, p[k].dep};
    return w;
  endfunction

  function automatic frag_t read_slot(input logic [WORD_W-1:0] cw, input logic [WORD_W-1:0] dw,
                                      input logic [IW-1:0] i);
    frag_t f;
    if (i == IDX_NONE) begin
      f = '0;
    end else begin
      f.col = cw[int'(i)*CW +: CW];
      f.dep = dw[int'(i)*EW +: DW];
      f.stn = dw[int'(i)*EW + DW +: SW];
    end
    return f;
  endfunction
endpackage

// File: rtl/mfc_palette.sv
module mfc_palette
  import mfc_pkg::*;
(
  input  logic [NS*CW-1:0] samp_c,
  input  logic [NS*DW-1:0] samp_d,
  input  logic [NS*SW-1:0] samp_s,
  output palette_t         pal,
  output logic [NS*IW-1:0] idx,
  output logic [IW-1:0]    used_cnt,
  output logic             overflow
);
  int          used;
  logic        hit;
  logic [IW-1:0] sel;
  frag_t       f;

  always_comb begin
    pal      = '0;
    idx      = '0;
    overflow = 1'b0;
    used     = 0;
    hit      = 1'b0;
    sel      = IDX_NONE;
    f        = '0;
    for (int s = 0; s < NS; s++) begin
      f   = frag_at(samp_c, samp_d, samp_s, s);
      hit = 1'b0;
      sel = IDX_NONE;
      for (int k = 0; k < NSLOT; k++) begin
        if (!hit && (k < used) && (pal[k] == f)) begin
          hit = 1'b1;
          sel = IW'(k);
        end
      end
      if (!hit) begin
        if (used < NSLOT) begin
          pal[used] = f;
          sel       = IW'(used);
          used      = used + 1;
        end else begin
          overflow = 1'b1;
        end
      end
      idx[s*IW +: IW] = sel;
    end
    used_cnt = IW'(used);
  end
endmodule

// File: rtl/mfc_pack_stage.sv
module mfc_pack_stage
  import mfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s1_v,
  input  logic [NS*CW-1:0]  s1_c,
  input  logic [NS*DW-1:0]  s1_d,
  input  logic [NS*SW-1:0]  s1_s,
  input  palette_t          pal,
  input  logic [NS*IW-1:0]  idx,
  input  logic              overflow,
  output logic              o_valid,
  output logic              o_uncomp,
  output logic [WORD_W-1:0] o_cw,
  output logic [WORD_W-1:0] o_dw,
  output logic [NS*CW-1:0]  o_raw_c,
  output logic [NS*DW-1:0]  o_raw_d,
  output logic [NS*SW-1:0]  o_raw_s
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_valid  <= 1'b0;
      o_uncomp <= 1'b0;
      o_cw     <= '0;
      o_dw     <= '0;
      o_raw_c  <= '0;
      o_raw_d  <= '0;
      o_raw_s  <= '0;
    end else begin
      o_valid  <= s1_v;
      o_uncomp <= s1_v && overflow;
      if (s1_v && overflow) begin
        o_cw    <= '0;
        o_dw    <= '0;
        o_raw_c <= s1_c;
        o_raw_d <= s1_d;
        o_raw_s <= s1_s;
      end else begin
        o_cw    <= make_color_word(pal, idx);
        o_dw    <= make_ds_word(pal);
        o_raw_c <= '0;
        o_raw_d <= '0;
        o_raw_s <= '0;
      end
    end
  end
endmodule

// File: rtl/mfc_unpack.sv
module mfc_unpack
  import mfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_valid,
  input  logic [WORD_W-1:0] i_cw,
  input  logic [WORD_W-1:0] i_dw,
  output logic              o_valid,
  output logic [NS*CW-1:0]  o_c,
  output logic [NS*DW-1:0]  o_d,
  output logic [NS*SW-1:0]  o_s
);
  logic [NS*CW-1:0] dec_c;
  logic [NS*DW-1:0] dec_d;
  logic [NS*SW-1:0] dec_s;

  for (genvar s = 0; s < NS; s++) begin : g_samp
    frag_t f;
    assign f = read_slot(i_cw, i_dw, i_cw[IDX_LO + s*IW +: IW]);
    assign dec_c[s*CW +: CW] = f.col;
    assign dec_d[s*DW +: DW] = f.dep;
    assign dec_s[s*SW +: SW] = f.stn;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_c     <= '0;
      o_d     <= '0;
      o_s     <= '0;
    end else begin
      o_valid <= i_valid;
      if (i_valid) begin
        o_c <= dec_c;
        o_d <= dec_d;
        o_s <= dec_s;
      end
    end
  end
endmodule

// File: rtl/msaa_frag_codec.sv
module msaa_frag_codec
  import mfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [NS*CW-1:0]  in_color,
  input  logic [NS*DW-1:0]  in_depth,
  input  logic [NS*SW-1:0]  in_stencil,
  output logic              out_valid,
  output logic              out_uncomp,
  output logic [WORD_W-1:0] out_color_word,
  output logic [WORD_W-1:0] out_ds_word,
  output logic [NS*CW-1:0]  out_raw_color,
  output logic [NS*DW-1:0]  out_raw_depth,
  output logic [NS*SW-1:0]  out_raw_stencil,
  input  logic              un_valid,
  input  logic [WORD_W-1:0] un_color_word,
  input  logic [WORD_W-1:0] un_ds_word,
  output logic              un_out_valid,
  output logic [NS*CW-1:0]  un_color,
  output logic [NS*DW-1:0]  un_depth,
  output logic [NS*SW-1:0]  un_stencil
);
  logic             s1_v;
  logic [NS*CW-1:0] s1_c;
  logic [NS*DW-1:0] s1_d;
  logic [NS*SW-1:0] s1_s;

  palette_t         pal;
  logic [NS*IW-1:0] pal_idx;
  logic [IW-1:0]    pal_cnt;
  logic             pal_ovf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
      s1_c <= '0;
      s1_d <= '0;
      s1_s <= '0;
    end else begin
      s1_v <= in_valid;
      s1_c <= in_color;
      s1_d <= in_depth;
      s1_s <= in_stencil;
    end
  end

  mfc_palette u_pal (
    .samp_c(s1_c), .samp_d(s1_d), .samp_s(s1_s),
    .pal(pal), .idx(pal_idx), .used_cnt(pal_cnt), .overflow(pal_ovf)
  );

  mfc_pack_stage u_pack (
    .clk(clk), .rst_n(rst_n),
    .s1_v(s1_v), .s1_c(s1_c), .s1_d(s1_d), .s1_s(s1_s),
    .pal(pal), .idx(pal_idx), .overflow(pal_ovf),
    .o_valid(out_valid), .o_uncomp(out_uncomp),
    .o_cw(out_color_word), .o_dw(out_ds_word),
    .o_raw_c(out_raw_color), .o_raw_d(out_raw_depth), .o_raw_s(out_raw_stencil)
  );

  mfc_unpack u_unpack (
    .clk(clk), .rst_n(rst_n),
    .i_valid(un_valid), .i_cw(un_color_word), .i_dw(un_ds_word),
    .o_valid(un_out_valid), .o_c(un_color), .o_d(un_depth), .o_s(un_stencil)
  );
endmodule

// File: rtl/mfc_checker.sv
module mfc_checker
  import mfc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              out_valid,
  input logic              out_uncomp,
  input logic [WORD_W-1:0] out_color_word,
  input logic [WORD_W-1:0] out_ds_word,
  input logic [NS*CW-1:0]  out_raw_color,
  input logic              un_valid,
  input logic              un_out_valid,
  input logic              s1_v,
  input logic              pal_ovf,
  input logic [IW-1:0]     pal_cnt
);
  logic any_none;
  always_comb begin
    any_none = 1'b0;
    for (int s = 0; s < NS; s++)
      if (out_color_word[IDX_LO + s*IW +: IW] == IDX_NONE) any_none = 1'b1;
  end

  // R1
  pack_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);
  // R1
  pack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid);
  // R3
  ds_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_ds_word[WORD_W-1:PAD_LO] == '0);
  // R4
  first_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_uncomp) |-> out_color_word[IDX_LO +: IW] == '0);
  // R6
  no_reserved_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_uncomp) |-> !any_none);
  // R7
  fallback_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_uncomp) |-> (out_color_word == '0 && out_ds_word == '0));
  // R7
  raw_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_uncomp) |-> out_raw_color == '0);
  // R7
  ovf_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && pal_ovf) |-> pal_cnt == IW'(NSLOT));
  // R8
  unpack_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    un_valid |=> un_out_valid);
  // R8
  unpack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !un_valid |=> !un_out_valid);
endmodule

bind msaa_frag_codec mfc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .out_valid(out_valid), .out_uncomp(out_uncomp),
  .out_color_word(out_color_word), .out_ds_word(out_ds_word),
  .out_raw_color(out_raw_color),
  .un_valid(un_valid), .un_out_valid(un_out_valid),
  .s1_v(s1_v), .pal_ovf(pal_ovf), .pal_cnt(pal_cnt)
);

// File: tb/sim_msaa_frag_codec.sv
module sim_msaa_frag_codec;
  typedef struct packed {
    logic [511:0] c;
    logic [511:0] d;
    logic [127:0] s;
  } pix_t;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [511:0] in_color, in_depth;
  logic [127:0] in_stencil;
  logic         out_valid, out_uncomp;
  logic [127:0] out_color_word, out_ds_word;
  logic [511:0] out_raw_color, out_raw_depth;
  logic [127:0] out_raw_stencil;
  logic         un_valid;
  logic [127:0] un_color_word, un_ds_word;
  logic         un_out_valid;
  logic [511:0] un_color, un_depth;
  logic [127:0] un_stencil;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  msaa_frag_codec u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [71:0] frag(input pix_t p, input int s);
    return {p.c[s*32 +: 32], p.d[s*32 +: 32], p.s[s*8 +: 8]};
  endfunction

  // Independent model: rank each sample by the first sample equal to it.
  function automatic void model(input pix_t p, output logic [127:0] cw, output logic [127:0] dw, output bit unc);
    int rank[16];
    int nd;
    int j;
    logic [71:0] f;
    nd = 0; cw = '0; dw = '0;
    for (int s = 0; s < 16; s++) begin
      j = 0;
      while (frag(p, j) != frag(p, s)) j++;
      if (j == s) begin rank[s] = nd; nd++; end
      else rank[s] = rank[j];
    end
    unc = (nd > 3);
    if (!unc) begin
      for (int s = 0; s < 16; s++) begin
        cw[96 + 2*s +: 2] = 2'(rank[s]);
        f = frag(p, s);
        cw[32*rank[s] +: 32] = f[71:40];
        dw[40*rank[s] +: 40] = {f[7:0], f[39:8]};
      end
    end
  endfunction

  function automatic pix_t build(input logic [71:0] pool[4], input int nd, input bit seq);
    pix_t p;
    int k;
    for (int s = 0; s < 16; s++) begin
      k = seq ? (s % nd) : int'($urandom % nd);
      p.c[s*32 +: 32] = pool[k][71:40];
      p.d[s*32 +: 32] = pool[k][39:8];
      p.s[s*8 +: 8]   = pool[k][7:0];
    end
    return p;
  endfunction

  pix_t stim[$];
  pix_t exp_q[$];
  pix_t rt_q[$];
  bit   ph0, ph1, uh0;

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [71:0] pool[4];
    logic [127:0] ecw, edw;
    bit eunc;
    pix_t e, p;
    void'($urandom(32'd4177));

    rst_n = 1'b0; in_valid = 1'b0; in_color = '0; in_depth = '0; in_stencil = '0;
    un_valid = 1'b0; un_color_word = '0; un_ds_word = '0;
    ph0 = 0; ph1 = 0; uh0 = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!out_valid && !out_uncomp && !un_out_valid, "R11 valids in reset", {out_valid, out_uncomp, un_out_valid}, 0);
    chk(out_color_word == 0 && out_ds_word == 0, "R11 words in reset", {out_color_word, out_ds_word}, 0);
    rst_n = 1'b1;

    // Directed: single fragment (R4), three in order (R2, R3)
    pool[0] = 72'h11111111_22222222_33; pool[1] = 72'hAAAAAAAA_BBBBBBBB_CC;
    pool[2] = 72'h01020304_05060708_09; pool[3] = 72'hDEADBEEF_00000001_7F;
    stim.push_back(build(pool, 1, 1'b1));
    stim.push_back(build(pool, 3, 1'b1));
    // R5: differ only in stencil
    pool[1] = {pool[0][71:8], 8'h34};
    stim.push_back(build(pool, 2, 1'b1));
    // R7: four distinct fragments
    stim.push_back(build(pool, 4, 1'b1));
    // R4: first appearance differs from pool order
    p = build(pool, 3, 1'b1);
    p.c[31:0] = pool[2][71:40]; p.d[31:0] = pool[2][39:8]; p.s[7:0] = pool[2][7:0];
    stim.push_back(p);
    for (int i = 0; i < 300; i++) begin
      for (int k = 0; k < 4; k++) pool[k] = {$urandom, $urandom, 8'($urandom)};
      if ($urandom % 3 == 0) pool[1] = {pool[0][71:8], pool[0][7:0] ^ 8'h01};
      if ($urandom % 4 == 0) pool[2] = {pool[0][71:40], pool[0][39:8] + 32'd1, pool[0][7:0]};
      stim.push_back(build(pool, 1 + int'($urandom % 4), 1'b0));
    end

    while (stim.size() != 0 || exp_q.size() != 0 || rt_q.size() != 0 || uh0) begin
      @(negedge clk);
      // R8 unpacker timing and R10 round trip
      chk(un_out_valid == uh0, "R8 unpack valid", un_out_valid, uh0);
      if (un_out_valid && rt_q.size() != 0) begin
        e = rt_q.pop_front();
        chk(un_color == e.c, "R10 round trip colour", un_color, e.c);
        chk(un_depth == e.d, "R10 round trip depth", un_depth, e.d);
        chk(un_stencil == e.s, "R10 round trip stencil", un_stencil, e.s);
      end
      // R1 packer timing
      chk(out_valid == ph1, "R1 pack valid", out_valid, ph1);
      un_valid = 1'b0;
      if (out_valid && exp_q.size() != 0) begin
        e = exp_q.pop_front();
        model(e, ecw, edw, eunc);
        chk(out_uncomp == eunc, "R7 fallback flag", out_uncomp, eunc);
        chk(out_color_word == ecw, "R2 R4 R5 colour word", out_color_word, ecw);
        chk(out_ds_word == edw, "R3 depth word", out_ds_word, edw);
        if (eunc) begin
          chk({out_raw_color, out_raw_depth, out_raw_stencil} == e, "R7 raw pass", out_raw_color, e.c);
        end else begin
          chk(out_raw_color == 0 && out_raw_stencil == 0, "R7 raw zero", out_raw_color, 0);
          for (int s = 0; s < 16; s++)
            if (out_color_word[96 + 2*s +: 2] == 2'd3) chk(0, "R6 reserved index", s, 0);
          un_valid = 1'b1; un_color_word = out_color_word; un_ds_word = out_ds_word;
          rt_q.push_back(e);
        end
      end
      uh0 = un_valid;
      ph1 = ph0;
      if (stim.size() != 0 && ($urandom % 5 != 0)) begin
        p = stim.pop_front();
        in_valid = 1'b1; in_color = p.c; in_depth = p.d; in_stencil = p.s;
        exp_q.push_back(p);
      end else begin
        in_valid = 1'b0; in_color = {16{32'h5A5A5A5A}};
      end
      ph0 = in_valid;
    end

    // R9: directed decode with index 3 on every fourth sample
    @(negedge clk);
    in_valid = 1'b0;
    un_valid = 1'b1;
    un_color_word = '0; un_ds_word = '0;
    un_color_word[31:0] = 32'hC0000000; un_color_word[63:32] = 32'hC1111111; un_color_word[95:64] = 32'hC2222222;
    un_ds_word[39:0] = {8'hE0, 32'hD0000000}; un_ds_word[79:40] = {8'hE1, 32'hD1111111};
    un_ds_word[119:80] = {8'hE2, 32'hD2222222};
    for (int s = 0; s < 16; s++) un_color_word[96 + 2*s +: 2] = 2'(s % 4);
    for (int s = 0; s < 16; s++) begin
      e.c[s*32 +: 32] = (s % 4 == 3) ? 32'h0 : {4'hC, {7{4'(s % 4)}}};
      e.d[s*32 +: 32] = (s % 4 == 3) ? 32'h0 : {4'hD, {7{4'(s % 4)}}};
      e.s[s*8 +: 8]   = (s % 4 == 3) ? 8'h0  : {4'hE, 4'(s % 4)};
    end
    @(negedge clk);
    un_valid = 1'b0;
    chk(un_out_valid, "R8 unpack valid directed", un_out_valid, 1);
    chk(un_color == e.c, "R9 decode colour", un_color, e.c);
    chk(un_depth == e.d, "R9 decode depth", un_depth, e.d);
    chk(un_stencil == e.s, "R9 decode stencil", un_stencil, e.s);
    @(negedge clk);
    chk(!un_out_valid, "R8 unpack idle", un_out_valid, 0);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule